// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches a port of asynchronous input pins and raises one shared interrupt line when any pin meets the trigger condition chosen for it. Each pin has its own 32-bit control word on a simple register bus. A 4-bit trigger field in that word selects one of six behaviours: off, low level, high level, rising edge, falling edge, or either edge. The pins are brought into the clock domain inside the block by a two-stage synchroniser. Edge detection compares consecutive synchronised samples.

A detected condition sets a sticky flag for that pin in a shared status word. Software reads the status word to find the pins that need attention. It clears any subset of flags by writing ones to their bit positions. The interrupt output stays high while at least one flag is set. A level trigger keeps reasserting its flag on every cycle that the level persists, so the flag cannot be cleared until the pin leaves the active level. The register bus is a plain strobe interface. Writes take effect at the clock edge on which the write strobe is high. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every flag is clear, every trigger field reads 0, and `irq_o` is low.
- R2: The control word of pin p is at byte address 4*p. The trigger field is bits 19:16, and all other bits read as 0. A write to one pin's control word leaves every other pin's word unchanged.
- R3: Trigger code 0x9 sets the pin's flag on a low-to-high change. A pin change that is first sampled at clock edge k sets the flag at edge k+2, so the flag is not yet set after edge k+1. A high-to-low change does not set the flag.
- R4: Trigger code 0xA sets the flag on a high-to-low change only. Trigger code 0xB sets it on both kinds of change.
- R5: Trigger code 0xC sets the flag while the synchronised pin is 1, and code 0x8 sets it while the pin is 0. A clear written while the level holds does not clear the flag. Once the level has gone, a clear does clear it.
- R6: Trigger code 0x0 and the unused codes 0x1–0x7 and 0xD–0xF never set the flag, whatever the pin does.
- R7: The status word is at byte address 0xA0, with bit p holding pin p's flag. Writing 1 to bit p clears that flag. Writing 0 to a bit leaves it unchanged.
- R8: `irq_o` is high exactly when at least one flag is set.
- R9: If a trigger event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R10: A write that changes a pin's trigger field, including to 0x0, does not clear that pin's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Asynchronous input pins |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe, data is returned one cycle later |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
Two functions can act on the same flag in the same cycle: the detector setting it and a software write clearing it. The bench provokes this in two ways. For an edge trigger, it places the clearing write on exactly the clock edge where a freshly synchronised rising edge lands, with the flag already set from an earlier event. For a level trigger, it writes a clear while the pin holds the active level. In both cases the bench reads the status word afterwards and expects the flag still set. A control clear written with no event pending must leave the flag at 0, which shows that the clearing path works on its own.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [3:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_ANY  = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_e;

  localparam int TRIG_LSB  = 16;
  localparam int TRIG_W    = 4;
  localparam int STAT_ADDR = 'hA0;

  // Evaluate one pin's trigger condition from its current and previous sample.
  function automatic logic trig_hit(input logic [TRIG_W-1:0] code,
                                    input logic cur, input logic prv);
    logic hit;
    case (code)
      TRIG_LOW:  hit = ~cur;
      TRIG_RISE: hit = cur & ~prv;
      TRIG_FALL: hit = ~cur & prv;
      TRIG_ANY:  hit = cur ^ prv;
      TRIG_HIGH: hit = cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N_PINS = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] raw_i,
  output logic [N_PINS-1:0] sync_o
);
  logic [N_PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_trig_detect.sv
module pin_trig_detect
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PINS-1:0]        pin_s,
  input  logic [N_PINS*TRIG_W-1:0] codes,
  output logic [N_PINS-1:0]        evt
);
  logic [N_PINS-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= pin_s;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign evt[i] = trig_hit(codes[i*TRIG_W +: TRIG_W], pin_s[i], prv_q[i]);
  end
endmodule

// File: rtl/pin_flag_bank.sv
module pin_flag_bank #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] evt,
  input  logic [N_PINS-1:0] clr,
  output logic [N_PINS-1:0] flags,
  output logic              irq_o
);
  logic [N_PINS-1:0] flag_d;

  // A new event overrides a clear aimed at the same flag.
  always_comb flag_d = (flags & ~clr) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq_o <= 1'b0;
    end else begin
      flags <= flag_d;
      irq_o <= |flag_d;
    end
  end
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [N_PINS-1:0]        flags,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [N_PINS*TRIG_W-1:0] codes,
  output logic [N_PINS-1:0]        clr
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(N_PINS);
  localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(STAT_ADDR >> 2);

  logic [WORD_W-1:0] word;
  logic              is_ctrl, is_stat;
  logic [TRIG_W-1:0] code_q [N_PINS];
  logic              unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign is_ctrl     = int'(word) < N_PINS;
  assign is_stat     = word == STAT_WORD;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  assign clr = (bus_wr && is_stat) ? bus_wdata[N_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PINS; i++) code_q[i] <= '0;
    end else if (bus_wr && is_ctrl) begin
      for (int i = 0; i < N_PINS; i++)
        if (int'(word) == i) code_q[i] <= bus_wdata[TRIG_LSB +: TRIG_W];
    end
  end

  always_comb begin
    for (int i = 0; i < N_PINS; i++) codes[i*TRIG_W +: TRIG_W] = code_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (is_stat)
        bus_rdata[N_PINS-1:0] <= flags;
      else if (is_ctrl)
        bus_rdata[TRIG_LSB +: TRIG_W] <= code_q[word[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [N_PINS-1:0]        pin_s;
  logic [N_PINS-1:0]        evt;
  logic [N_PINS-1:0]        clr;
  logic [N_PINS-1:0]        flags;
  logic [N_PINS*TRIG_W-1:0] codes;

  pin_sync #(.N_PINS(N_PINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pin_s)
  );

  pin_cfg_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flags),
    .bus_rdata(bus_rdata), .codes(codes), .clr(clr)
  );

  pin_trig_detect #(.N_PINS(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .codes(codes), .evt(evt)
  );

  pin_flag_bank #(.N_PINS(N_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr),
    .flags(flags), .irq_o(irq_o)
  );
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic [N_PINS-1:0] flags,
  input logic [N_PINS-1:0] evt,
  input logic [N_PINS-1:0] pin_s,
  input logic [N_PINS*4-1:0] codes,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  logic stat_wr;
  assign stat_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('hA0 >> 2));

  // R8: the combined line tracks the flag word
  a_r8_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flags != '0));

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    logic [3:0] c;
    logic       c_live;
    assign c      = codes[i*4 +: 4];
    assign c_live = c inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC};

    // R9: an event always leaves its flag set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);

    // R7, R10: a set flag only drops through a one written to its status bit
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !(stat_wr && bus_wdata[i]) |=> flags[i]);

    // R6: off or unused codes never raise a flag
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[i] && !c_live |=> !flags[i]);

    // R5: a held high level keeps the flag set
    a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'hC) && pin_s[i] |=> flags[i]);
  end
endmodule

bind pin_irq_ctrl pin_irq_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .flags(flags), .evt(evt),
  .pin_s(pin_s), .codes(codes), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/sim_pin_irq_ctrl.sv
module sim_pin_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] STAT = 8'hA0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick(1);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_code(input int p, input logic [3:0] c);
    wr(AW'(p*4), DW'(c) << 16);
  endtask

  task automatic clear_all();
    wr(STAT, '1);
    tick(1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 irq", DW'(irq_o), 0);
    rd(STAT, d);        check("R1 status", d, 0);
    rd(AW'(5*4), d);    check("R1 ctrl5", d, 0);
  endtask

  task automatic t_ctrl_map();
    logic [DW-1:0] d;
    wr(AW'(3*4), 32'hFFFF_FFFF);
    rd(AW'(3*4), d);    check("R2 field only", d, 32'h000F_0000);
    rd(AW'(4*4), d);    check("R2 neighbour", d, 0);
    set_code(31, 4'h9);
    rd(AW'(31*4), d);   check("R2 pin31", d, 32'h0009_0000);
    set_code(3, 4'h0);
    set_code(31, 4'h0);
  endtask

  task automatic t_rising();
    logic [DW-1:0] d;
    set_code(3, 4'h9);
    pin[3] = 1'b1;
    tick(2);            check("R3 not yet", DW'(irq_o), 0);
    tick(1);            check("R3 latency", DW'(irq_o), 1);
    rd(STAT, d);        check("R3 status", d, 32'h8);
    clear_all();
    pin[3] = 1'b0;
    tick(4);
    rd(STAT, d);        check("R3 fall ignored", d, 0);
  endtask

  task automatic t_fall_any();
    logic [DW-1:0] d;
    set_code(7, 4'hA);
    set_code(9, 4'hB);
    pin[7] = 1'b1; pin[9] = 1'b1;
    tick(4);
    rd(STAT, d);        check("R4 rise", d, 32'h200);
    clear_all();
    pin[7] = 1'b0; pin[9] = 1'b0;
    tick(4);
    rd(STAT, d);        check("R4 fall", d, 32'h280);
    clear_all();
    set_code(7, 4'h0); set_code(9, 4'h0);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    set_code(12, 4'hC);
    pin[12] = 1'b1;
    tick(4);
    wr(STAT, 32'h1000);
    tick(1);
    rd(STAT, d);        check("R5 high holds", d, 32'h1000);
    pin[12] = 1'b0;
    tick(4);
    clear_all();
    rd(STAT, d);        check("R5 high gone", d, 0);
    set_code(12, 4'h0);
    pin[13] = 1'b1;
    tick(3);
    set_code(13, 4'h8);
    tick(3);
    rd(STAT, d);        check("R5 low idle", d, 0);
    pin[13] = 1'b0;
    tick(4);
    wr(STAT, 32'h2000);
    rd(STAT, d);        check("R5 low holds", d, 32'h2000);
    pin[13] = 1'b1;
    tick(4);
    clear_all();
    rd(STAT, d);        check("R5 low gone", d, 0);
    set_code(13, 4'h0);
  endtask

  task automatic t_disabled();
    logic [DW-1:0] d;
    set_code(21, 4'h5);
    set_code(22, 4'hF);
    set_code(23, 4'hD);
    for (int k = 0; k < 3; k++) begin
      pin[23:20] = 4'hF; tick(3);
      pin[23:20] = 4'h0; tick(3);
    end
    rd(STAT, d);        check("R6 off/unused", d, 0);
    check("R6 irq", DW'(irq_o), 0);
    set_code(21, 4'h0); set_code(22, 4'h0); set_code(23, 4'h0);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    set_code(3, 4'h9); set_code(9, 4'h9);
    pin[3] = 1'b1; pin[9] = 1'b1;
    tick(4);
    wr(STAT, 32'h0);
    rd(STAT, d);        check("R7 zero write", d, 32'h208);
    wr(STAT, 32'h8);
    rd(STAT, d);        check("R7 one bit", d, 32'h200);
    check("R8 irq one flag", DW'(irq_o), 1);
    wr(STAT, 32'h200);
    tick(1);
    check("R8 irq none", DW'(irq_o), 0);
    pin[3] = 1'b0; pin[9] = 1'b0;
    tick(4);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    pin[3] = 1'b1; tick(4);
    pin[3] = 1'b0; tick(4);
    check("R9 preset", DW'(irq_o), 1);
    pin[3] = 1'b1;
    tick(2);
    wr(STAT, 32'h8);
    rd(STAT, d);        check("R9 event beats clear", d, 32'h8);
    clear_all();
    rd(STAT, d);        check("R9 plain clear", d, 0);
    pin[3] = 1'b0; tick(4);
    clear_all();
  endtask

  task automatic t_code_change();
    logic [DW-1:0] d;
    pin[3] = 1'b1; tick(4);
    set_code(3, 4'h0);
    rd(STAT, d);        check("R10 flag kept", d, 32'h8);
    check("R10 irq kept", DW'(irq_o), 1);
    clear_all();
    pin[3] = 1'b0; tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_ctrl_map();
    t_rising();
    t_fall_any();
    t_level();
    t_disabled();
    t_w1c();
    t_collide();
    t_code_change();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule